// File: doc/BRIEF.md
# Asynchronous Exception Arbiter

This block gathers the asynchronous exception requests of a small in-order RISC core, sorts them by class and priority, and issues one exception-take request per cycle. With the take it supplies the handler's vector offset, a cause code, the address at which execution resumes, and a flag that says whether the interrupted context can be resumed. It also holds the core's global interrupt-enable bit. The bit is set by a restore strobe and cleared by every take.

There are two non-maskable sources. The first is a system reset, raised by a soft or a hard reset pin. The second is a machine check, merged from a bus transfer error seen during a data transaction, a dedicated pin, and the address and data parity strobes. Both are captured on their rising edge and are taken at once, whatever the interrupt-enable bit and the pipeline are doing. There are three maskable sources: the system-management interrupt, the external interrupt and the decrementer. They are taken only when interrupts are enabled, and only at an instruction boundary: either the in-flight instruction completes in that cycle, or the execution units are empty. External and system-management requests are level-sensitive. A decrementer event stays pending until it is taken.

All outputs are registered. The inputs present in cycle t are reflected on the outputs after the clock edge that ends cycle t.

Top module: `exc_arbiter`

## Requirements
- R1: A rising edge on `soft_rst_pin` or `hard_rst_pin` produces a take with cause code 1 and vector 0x00100 on the next cycle.
- R2: A machine check (cause code 2, vector 0x00200) is raised by any of: `mchk_pin`, `addr_par_err`, `data_par_err`, or `bus_xfer_err` while `bus_data_xact` is high. `bus_xfer_err` alone does not raise it.
- R3: While `exc_take` is high, `exc_vector` is never 0x00000. While `exc_take` is low, `exc_vector`, `exc_cause` and `restart_pc` read zero.
- R4: System reset and machine check are taken whatever the values of `int_en`, `pipe_busy` and `instr_done`.
- R5: A system-management, external or decrementer exception is taken only if `int_en` is 1 in the deciding cycle.
- R6: A maskable exception is taken only in a cycle where `pipe_busy` is low or `instr_done` is high.
- R7: When several sources are eligible, the fixed priority from highest to lowest is: system reset, machine check, system-management, external, decrementer. Exactly one source is taken.
- R8: The maskable sources use these cause codes and vectors: system-management 3 and 0x01400, external 4 and 0x00500, decrementer 5 and 0x00900.
- R9: `int_en` is 0 after reset. A pulse on `int_en_set` makes it 1. Every take makes it 0, and a take wins over a set in the same cycle.
- R10: A pulse on `dec_irq` stays pending until the decrementer exception is taken. An external or system-management request that drops before it is eligible is never taken.
- R11: `restart_pc` on a take equals the value `next_pc` had in the deciding cycle.
- R12: `recoverable` is 0 on a system-reset or machine-check take and 1 on a maskable take.
- R13: A non-maskable pin held high for many cycles gives exactly one take, and `exc_take` never stays high for two cycles with the same cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the block's state |
| soft_rst_pin | input | 1 | Soft system-reset request |
| hard_rst_pin | input | 1 | Hard system-reset request |
| bus_xfer_err | input | 1 | Bus transfer-error indication |
| bus_data_xact | input | 1 | High while a data bus transaction is in progress |
| mchk_pin | input | 1 | Machine-check request pin |
| addr_par_err | input | 1 | Address parity-error strobe |
| data_par_err | input | 1 | Data parity-error strobe |
| smi_irq | input | 1 | System-management interrupt request (level) |
| ext_irq | input | 1 | External interrupt request (level) |
| dec_irq | input | 1 | Decrementer event (pulse, latched) |
| int_en_set | input | 1 | Sets the interrupt-enable bit (return from handler) |
| pipe_busy | input | 1 | An instruction occupies the execution units |
| instr_done | input | 1 | The in-flight instruction completes this cycle |
| next_pc | input | AW | Address of the next instruction to execute |
| exc_take | output | 1 | Exception-take strobe |
| exc_cause | output | 3 | Cause code of the take (0 when none) |
| exc_vector | output | 20 | Vector offset of the take |
| restart_pc | output | AW | Address to be saved for resumption |
| recoverable | output | 1 | Interrupted context can be resumed |
| int_en | output | 1 | Global interrupt-enable bit |

## Verification
On every cycle the assertions check the following. A take never carries the reserved vector. The priority grant is at most one-hot. A maskable take happens only with interrupts enabled and at an instruction boundary. The enable bit is clear after a take, the restart address matches the one sampled, recoverability follows the class, and no cause repeats in back-to-back takes. Only the bench's scenarios can show the rest: the exact priority order and vector for each mix of sources, the merging of the machine-check sources (the bus error must be qualified), the sticky decrementer against the level-sensitive external request, and the single take from a held reset pin.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int VEC_W = 20;
  localparam int NSRC  = 5;   // grant index = priority rank, 0 highest

  localparam int IX_SRESET = 0;
  localparam int IX_MCHK   = 1;
  localparam int IX_SMI    = 2;
  localparam int IX_EXT    = 3;
  localparam int IX_DEC    = 4;

  typedef enum logic [2:0] {
    CZ_NONE   = 3'd0,
    CZ_SRESET = 3'd1,
    CZ_MCHK   = 3'd2,
    CZ_SMI    = 3'd3,
    CZ_EXT    = 3'd4,
    CZ_DEC    = 3'd5
  } cause_e;

  // Keep only the lowest-index (highest priority) request.
  function automatic logic [NSRC-1:0] pick_first(input logic [NSRC-1:0] req);
    logic [NSRC-1:0] g;
    logic            found;
    g     = '0;
    found = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && !found) begin
        g[i]  = 1'b1;
        found = 1'b1;
      end
    end
    return g;
  endfunction

  function automatic cause_e cause_of(input logic [NSRC-1:0] grant);
    cause_e c;
    c = CZ_NONE;
    if (grant[IX_SRESET])    c = CZ_SRESET;
    else if (grant[IX_MCHK]) c = CZ_MCHK;
    else if (grant[IX_SMI])  c = CZ_SMI;
    else if (grant[IX_EXT])  c = CZ_EXT;
    else if (grant[IX_DEC])  c = CZ_DEC;
    return c;
  endfunction

  function automatic logic [VEC_W-1:0] vec_of(input cause_e c);
    logic [VEC_W-1:0] v;
    case (c)
      CZ_SRESET: v = VEC_W'('h00100);
      CZ_MCHK:   v = VEC_W'('h00200);
      CZ_SMI:    v = VEC_W'('h01400);
      CZ_EXT:    v = VEC_W'('h00500);
      CZ_DEC:    v = VEC_W'('h00900);
      default:   v = '0;
    endcase
    return v;
  endfunction

  function automatic logic is_maskable(input cause_e c);
    return (c == CZ_SMI) || (c == CZ_EXT) || (c == CZ_DEC);
  endfunction

  function automatic logic recov_of(input cause_e c);
    return is_maskable(c);
  endfunction

endpackage

// File: rtl/exc_pend_latch.sv
module exc_pend_latch #(
  parameter bit EDGE = 1'b1   // 1: capture rising edge, 0: capture high level
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic ack,
  output logic active
);

  logic pend_q;
  logic evt;

  generate
    if (EDGE) begin : g_edge
      logic req_d;
      always_ff @(posedge clk) begin
        if (!rst_n) req_d <= 1'b0;
        else        req_d <= req;
      end
      assign evt = req & ~req_d;
    end else begin : g_level
      assign evt = req;
    end
  endgenerate

  assign active = pend_q | evt;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= active & ~ack;
  end

  // R10: a pending request is cleared only by its acknowledge
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !ack) |=> pend_q);

endmodule

// File: rtl/exc_prio_select.sv
module exc_prio_select
  import exc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      nm_req,    // {mchk, sreset}
  input  logic [2:0]      mk_req,    // {dec, ext, smi}
  input  logic            mask_ok,
  output logic [NSRC-1:0] grant,
  output cause_e          cause
);

  logic [NSRC-1:0] req;
  logic            mk_granted;

  assign req        = {mk_req & {3{mask_ok}}, nm_req};
  assign grant      = pick_first(req);
  assign cause      = cause_of(grant);
  assign mk_granted = |grant[NSRC-1:IX_SMI];

  // R7: a single winner at most
  a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R7 / R4: a non-maskable request always beats the maskable ones
  a_r7_nm_first: assert property (@(posedge clk) disable iff (!rst_n)
    (|nm_req) |-> !mk_granted);

  // R5 / R6: maskable wins only when the gate is open
  a_r5_gate: assert property (@(posedge clk) disable iff (!rst_n)
    mk_granted |-> mask_ok);

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst_pin,
  input  logic             hard_rst_pin,
  input  logic             bus_xfer_err,
  input  logic             bus_data_xact,
  input  logic             mchk_pin,
  input  logic             addr_par_err,
  input  logic             data_par_err,
  input  logic             smi_irq,
  input  logic             ext_irq,
  input  logic             dec_irq,
  input  logic             int_en_set,
  input  logic             pipe_busy,
  input  logic             instr_done,
  input  logic [AW-1:0]    next_pc,
  output logic             exc_take,
  output logic [2:0]       exc_cause,
  output logic [VEC_W-1:0] exc_vector,
  output logic [AW-1:0]    restart_pc,
  output logic             recoverable,
  output logic             int_en
);

  // Named internal events
  logic            sreset_raw;
  logic            mchk_raw;
  logic            sreset_act;
  logic            mchk_act;
  logic            dec_act;
  logic            boundary;
  logic            mask_ok;
  logic [NSRC-1:0] grant;
  cause_e          win_cause;
  logic            take_n;
  logic            ie_q;

  assign sreset_raw = soft_rst_pin | hard_rst_pin;
  assign mchk_raw   = (bus_xfer_err & bus_data_xact) | mchk_pin
                    | addr_par_err | data_par_err;
  assign boundary   = ~pipe_busy | instr_done;
  assign mask_ok    = ie_q & boundary;

  exc_pend_latch #(.EDGE(1'b1)) u_sreset (
    .clk(clk), .rst_n(rst_n), .req(sreset_raw),
    .ack(grant[IX_SRESET]), .active(sreset_act)
  );

  exc_pend_latch #(.EDGE(1'b1)) u_mchk (
    .clk(clk), .rst_n(rst_n), .req(mchk_raw),
    .ack(grant[IX_MCHK]), .active(mchk_act)
  );

  exc_pend_latch #(.EDGE(1'b0)) u_dec (
    .clk(clk), .rst_n(rst_n), .req(dec_irq),
    .ack(grant[IX_DEC]), .active(dec_act)
  );

  exc_prio_select u_prio (
    .clk(clk), .rst_n(rst_n),
    .nm_req({mchk_act, sreset_act}),
    .mk_req({dec_act, ext_irq, smi_irq}),
    .mask_ok(mask_ok),
    .grant(grant),
    .cause(win_cause)
  );

  assign take_n = |grant;

  // Interrupt-enable bit: take wins over set
  always_ff @(posedge clk) begin
    if (!rst_n)          ie_q <= 1'b0;
    else if (take_n)     ie_q <= 1'b0;
    else if (int_en_set) ie_q <= 1'b1;
  end

  // Registered take outputs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_take    <= 1'b0;
      exc_cause   <= 3'd0;
      exc_vector  <= '0;
      restart_pc  <= '0;
      recoverable <= 1'b0;
    end else begin
      exc_take    <= take_n;
      exc_cause   <= win_cause;
      exc_vector  <= vec_of(win_cause);
      restart_pc  <= take_n ? next_pc : '0;
      recoverable <= take_n & recov_of(win_cause);
    end
  end

  assign int_en = ie_q;

  // R3: reserved vector never issued
  a_r3_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |-> (exc_vector != '0));

  // R5: maskable take needs interrupts enabled in the deciding cycle
  a_r5_ie_needed: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && is_maskable(cause_e'(exc_cause))) |-> $past(ie_q));

  // R6: maskable take only at an instruction boundary
  a_r6_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && is_maskable(cause_e'(exc_cause))) |-> $past(boundary));

  // R9: enable bit is clear after any take
  a_r9_ie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |-> !ie_q);

  // R11: restart address is the sampled next address
  a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |-> (restart_pc == $past(next_pc)));

  // R12: recoverability follows the class
  a_r12_recov: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |-> (recoverable == is_maskable(cause_e'(exc_cause))));

  // R13: no cause repeats in back-to-back takes
  a_r13_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && $past(exc_take)) |-> (exc_cause != $past(exc_cause)));

endmodule

// File: tb/exc_arbiter_test.sv
module exc_arbiter_test;

  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst_pin = 0, hard_rst_pin = 0, bus_xfer_err = 0, bus_data_xact = 0;
  logic mchk_pin = 0, addr_par_err = 0, data_par_err = 0;
  logic smi_irq = 0, ext_irq = 0, dec_irq = 0, int_en_set = 0;
  logic pipe_busy = 0, instr_done = 0;
  logic [AW-1:0] next_pc = '0;
  logic          exc_take;
  logic [2:0]    exc_cause;
  logic [19:0]   exc_vector;
  logic [AW-1:0] restart_pc;
  logic          recoverable;
  logic          int_en;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  exc_arbiter #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .soft_rst_pin(soft_rst_pin), .hard_rst_pin(hard_rst_pin),
    .bus_xfer_err(bus_xfer_err), .bus_data_xact(bus_data_xact),
    .mchk_pin(mchk_pin), .addr_par_err(addr_par_err), .data_par_err(data_par_err),
    .smi_irq(smi_irq), .ext_irq(ext_irq), .dec_irq(dec_irq),
    .int_en_set(int_en_set), .pipe_busy(pipe_busy), .instr_done(instr_done),
    .next_pc(next_pc),
    .exc_take(exc_take), .exc_cause(exc_cause), .exc_vector(exc_vector),
    .restart_pc(restart_pc), .recoverable(recoverable), .int_en(int_en)
  );

  // Bench's own vector table, by cause code
  function automatic logic [19:0] exp_vec(input int c);
    case (c)
      1: return 20'h00100;
      2: return 20'h00200;
      3: return 20'h01400;
      4: return 20'h00500;
      5: return 20'h00900;
      default: return 20'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_inputs();
    soft_rst_pin = 0; hard_rst_pin = 0; bus_xfer_err = 0; bus_data_xact = 0;
    mchk_pin = 0; addr_par_err = 0; data_par_err = 0;
    smi_irq = 0; ext_irq = 0; dec_irq = 0; int_en_set = 0;
    pipe_busy = 0; instr_done = 0;
  endtask

  task automatic do_reset();
    clear_inputs();
    rst_n = 0;
    step(); step();
    rst_n = 1;
    step();
  endtask

  task automatic enable_ie();
    int_en_set = 1;
    step();
    int_en_set = 0;
  endtask

  // Check a complete take (or absence) against the cause code expected
  task automatic chk_take(input string req, input int c, input logic [31:0] pc);
    chk(req, exc_take, c != 0);
    chk(req, exc_cause, c);
    chk(req, exc_vector, exp_vec(c));
    chk(req, restart_pc, (c != 0) ? pc : 32'h0);
    chk(req, recoverable, c >= 3);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int takes;
    do_reset();
    // Reset state (R9, R3)
    chk("R9 reset int_en", int_en, 0);
    chk_take("R3 reset idle", 0, 0);

    // R7 R8 R12 R11: sweep all mixes with interrupts enabled, pipe idle
    for (int m = 0; m < 32; m++) begin
      int c;
      do_reset();
      enable_ie();
      chk("R9 set", int_en, 1);
      soft_rst_pin = m[0]; mchk_pin = m[1]; smi_irq = m[2];
      ext_irq = m[3]; dec_irq = m[4];
      next_pc = 32'h1000 + m * 4;
      step();
      c = 0;
      for (int b = 4; b >= 0; b--) if (m[b]) c = b + 1;
      chk_take("R7 priority", c, 32'h1000 + m * 4);
      if (c != 0) chk("R9 cleared", int_en, 0);
    end

    // R4 R5: same sweep with interrupts disabled and pipe busy
    for (int m = 0; m < 32; m++) begin
      int c;
      do_reset();
      hard_rst_pin = m[0]; mchk_pin = m[1]; smi_irq = m[2];
      ext_irq = m[3]; dec_irq = m[4]; pipe_busy = 1;
      next_pc = 32'h2000 + m;
      step();
      c = m[0] ? 1 : (m[1] ? 2 : 0);
      chk_take("R4 R5 nonmaskable only", c, 32'h2000 + m);
    end

    // R2: machine-check source merge
    for (int m = 0; m < 32; m++) begin
      logic e;
      do_reset();
      bus_xfer_err = m[0]; bus_data_xact = m[1]; mchk_pin = m[2];
      addr_par_err = m[3]; data_par_err = m[4];
      next_pc = 32'h3000;
      step();
      e = (m[0] & m[1]) | m[2] | m[3] | m[4];
      chk_take("R2 mchk merge", e ? 2 : 0, 32'h3000);
    end

    // R6 R5: external gating over enable, busy, done
    for (int m = 0; m < 8; m++) begin
      logic e;
      do_reset();
      if (m[0]) enable_ie();
      ext_irq = 1; pipe_busy = m[1]; instr_done = m[2];
      next_pc = 32'h4000 + m;
      step();
      e = m[0] & (~m[1] | m[2]);
      chk_take("R6 boundary gate", e ? 4 : 0, 32'h4000 + m);
    end

    // R10: decrementer sticky while disabled, taken once enabled
    do_reset();
    dec_irq = 1; step(); dec_irq = 0;
    chk("R10 dec held off", exc_take, 0);
    step(); step();
    chk("R10 dec still off", exc_take, 0);
    int_en_set = 1; step(); int_en_set = 0;
    next_pc = 32'h5000;
    step();
    chk_take("R10 dec sticky", 5, 32'h5000);

    // R10: external request dropped before eligible is lost
    do_reset();
    ext_irq = 1; step(); ext_irq = 0;
    int_en_set = 1; step(); int_en_set = 0;
    step();
    chk("R10 ext level lost", exc_take, 0);
    chk("R10 ext ie kept", int_en, 1);

    // R9: take wins over a same-cycle set
    do_reset();
    mchk_pin = 1; int_en_set = 1;
    step();
    mchk_pin = 0; int_en_set = 0;
    chk("R9 take over set", int_en, 0);

    // R13 R1: soft reset held many cycles gives one take
    do_reset();
    soft_rst_pin = 1;
    takes = 0;
    for (int k = 0; k < 8; k++) begin
      step();
      if (exc_take) takes++;
    end
    soft_rst_pin = 0;
    chk("R13 R1 single take", takes, 1);

    // R7: reset and machine check together -> reset then mchk next cycle
    do_reset();
    soft_rst_pin = 1; mchk_pin = 1; next_pc = 32'h6000;
    step();
    chk_take("R7 R1 first", 1, 32'h6000);
    next_pc = 32'h6004;
    step();
    chk_take("R7 R2 second", 2, 32'h6004);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule